// File: doc/BRIEF.md
# Peripheral Register Block with Serial Port and Interrupt Control

This block sits on a 32-bit processor data bus. It answers single-cycle accesses inside a fixed I/O region whose top address nibble is 0x2. Inside that region it provides a serial data port, an interrupt enable (mask) register, an interrupt flag (status) register and a process-identifier register. A single registered interrupt line is raised whenever a flag is set and its enable bit is also set.

The serializer is not part of this block. The block hands it bytes over a ready/valid pair and takes in received bytes on a valid strobe. Several registers have side effects when accessed. Reading the data port drops the receive flag. Software may overwrite the flag register in one write. Any write into the translation-table window clears the fault flag. A free-running counter supplies two complementary phase flags.

A bus access is one cycle of `bus_sel`. Read data is combinational from the current register state in that same cycle. Write and read side effects take hold at the next clock edge.

Top module: `sysio_regs`

## Requirements
- R1: Only addresses with bits [31:28] = 0x2 are decoded. Accesses outside that region change no state (no byte is sent, no register changes) and read back 0.
- R2: A write to offset 0x000 with the transmitter idle raises `tx_valid` with `tx_byte` = wdata[7:0] at the next edge. Both are held stable until a cycle with `tx_ready` high. Flag bit 1 (value 0x002, transmit ready) clears when the byte is accepted and sets when the handshake completes. A data write while `tx_valid` is high is dropped.
- R3: A cycle with `rx_valid` high stores `rx_byte` and sets flag bit 0 (value 0x001). A read of offset 0x000 returns the stored byte zero-extended.
- R4: A read of offset 0x000 clears flag bit 0. If a new byte arrives in that same cycle, the bit stays set.
- R5: The enable register at offset 0x010 stores wdata[STAT_W-1:0] and reads back zero-extended (0x3FF for an all-ones write with STAT_W = 10).
- R6: A write to the flag register at offset 0x020 replaces all stored flag bits with wdata. Hardware set events in the same cycle take priority, and bits 2 and 3 always follow the counter.
- R7: Flag bit 3 (0x008) mirrors bit PHASE_BIT of a free-running counter and flag bit 2 (0x004) is always its complement.
- R8: A `mmu_fault` pulse sets flag bit 9 (0x200). Any write to an offset in [0x0A0, 0x0A0 + 8*TLB_ENT) clears it, and a write just past that window does not.
- R9: The process-ID register at offset 0x080 stores wdata[PID_W-1:0] and reads back zero-extended.
- R10: A write to offset 0x070 is accepted with no effect. Reads of undecoded offsets inside the region return 0.
- R11: `irq` is a register equal to the OR of (flags AND enables). It changes at the clock edge that ends the cycle of the causing event. After reset it is 0, the flags read 0x002 plus the phase bits, and the enables read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte pending |
| tx_byte | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Serializer accepts the pending byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| mmu_fault | input | 1 | Translation fault event pulse |
| irq | output | 1 | Interrupt request |

## Verification
If the flag register holds a wrong value, it shows up at `irq` at the very next edge whenever the matching enable bit is set. It also shows up on the next flag read. A transmit state machine stuck busy keeps `tx_valid` high and holds flag bit 1 clear, so later data writes vanish with no byte presented. A decoder that matches too wide or too narrow is visible in a single access. The read returns non-zero where zero is required, or a neighbouring register changes, as the config-write, window-edge and out-of-region probes show.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

    // flag bit positions (software decodes these)
    localparam int FLG_RX  = 0;
    localparam int FLG_TX  = 1;
    localparam int FLG_PLO = 2;
    localparam int FLG_PHI = 3;
    localparam int FLG_MMU = 9;

    // region and register offsets
    localparam logic [3:0]  REGION   = 4'h2;
    localparam logic [27:0] OFF_DATA = 28'h000_0000;
    localparam logic [27:0] OFF_ENA  = 28'h000_0010;
    localparam logic [27:0] OFF_FLG  = 28'h000_0020;
    localparam logic [27:0] OFF_CFG  = 28'h000_0070;
    localparam logic [27:0] OFF_PID  = 28'h000_0080;
    localparam logic [27:0] OFF_TLB  = 28'h000_00A0;

    typedef struct packed {
        logic data;
        logic ena;
        logic flg;
        logic cfg;
        logic pid;
        logic tlb;
    } hit_t;

endpackage

// File: rtl/sysio_dec.sv
module sysio_dec
    import sysio_pkg::*;
#(
    parameter int TLB_ENT = 4
) (
    input  logic        sel_i,
    input  logic [31:0] addr_i,
    output hit_t        hit_o
);
    localparam logic [27:0] TLB_END = OFF_TLB + 28'(TLB_ENT * 8);

    logic [27:0] off;

    always_comb begin
        off   = addr_i[27:0];
        hit_o = '0;
        if (sel_i && addr_i[31:28] == REGION) begin
            hit_o.data = (off == OFF_DATA);
            hit_o.ena  = (off == OFF_ENA);
            hit_o.flg  = (off == OFF_FLG);
            hit_o.cfg  = (off == OFF_CFG);
            hit_o.pid  = (off == OFF_PID);
            hit_o.tlb  = (off >= OFF_TLB) && (off < TLB_END);
        end
    end

endmodule

// File: rtl/sysio_phase.sv
module sysio_phase #(
    parameter int CNT_W     = 32,
    parameter int PHASE_BIT = 18
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign phase_o = cnt_q[PHASE_BIT];

endmodule

// File: rtl/sysio_regs.sv
module sysio_regs
    import sysio_pkg::*;
#(
    parameter int STAT_W    = 10,
    parameter int PID_W     = 8,
    parameter int TLB_ENT   = 4,
    parameter int CNT_W     = 32,
    parameter int PHASE_BIT = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_we,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_ready,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        mmu_fault,
    output logic        irq
);
    localparam logic [STAT_W-1:0] FLG_RST =
        STAT_W'((1 << FLG_TX) | (1 << FLG_PLO));

    typedef struct packed {
        logic [STAT_W-1:0] flg;
        logic [STAT_W-1:0] ena;
        logic [PID_W-1:0]  pid;
        logic [7:0]        rxb;
        logic [7:0]        txb;
        logic              txv;
        logic              irq;
    } state_t;

    state_t st_d, st_q;
    hit_t   hit;
    logic   phase;
    logic   wr, rd;
    logic   unused_wdata;

    assign unused_wdata = ^bus_wdata;

    sysio_dec #(.TLB_ENT(TLB_ENT)) u_dec (
        .sel_i  (bus_sel),
        .addr_i (bus_addr),
        .hit_o  (hit)
    );

    sysio_phase #(.CNT_W(CNT_W), .PHASE_BIT(PHASE_BIT)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase)
    );

    assign wr = bus_sel &  bus_we;
    assign rd = bus_sel & ~bus_we;

    always_comb begin
        st_d = st_q;
        // software writes first; hardware events below override
        if (wr && hit.ena) st_d.ena = bus_wdata[STAT_W-1:0];
        if (wr && hit.pid) st_d.pid = bus_wdata[PID_W-1:0];
        if (wr && hit.flg) st_d.flg = bus_wdata[STAT_W-1:0];

        if (st_q.txv && tx_ready) begin
            st_d.txv         = 1'b0;
            st_d.flg[FLG_TX] = 1'b1;
        end else if (wr && hit.data && !st_q.txv) begin
            st_d.txv         = 1'b1;
            st_d.txb         = bus_wdata[7:0];
            st_d.flg[FLG_TX] = 1'b0;
        end

        if (rd && hit.data) st_d.flg[FLG_RX] = 1'b0;
        if (rx_valid) begin
            st_d.flg[FLG_RX] = 1'b1;
            st_d.rxb         = rx_byte;
        end

        if (wr && hit.tlb) st_d.flg[FLG_MMU] = 1'b0;
        if (mmu_fault)     st_d.flg[FLG_MMU] = 1'b1;

        st_d.flg[FLG_PHI] = phase;
        st_d.flg[FLG_PLO] = ~phase;

        st_d.irq = |(st_d.flg & st_d.ena);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.flg <= FLG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            if (hit.data)     bus_rdata = 32'(st_q.rxb);
            else if (hit.ena) bus_rdata = 32'(st_q.ena);
            else if (hit.flg) bus_rdata = 32'(st_q.flg);
            else if (hit.pid) bus_rdata = 32'(st_q.pid);
        end
    end

    assign tx_valid = st_q.txv;
    assign tx_byte  = st_q.txb;
    assign irq      = st_q.irq;

    // R1
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R2
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R2
    tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_valid && st_q.flg[FLG_TX]));

    // R3
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (st_q.flg[FLG_RX] && st_q.rxb == $past(rx_byte)));

    // R7
    phase_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flg[FLG_PHI] != st_q.flg[FLG_PLO]);

    // R8
    mmu_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_fault |=> st_q.flg[FLG_MMU]);

    // R11
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(st_q.flg & st_q.ena));

endmodule

// File: tb/sysio_regs_tb.sv
`timescale 1ns/1ps
module sysio_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        mmu_fault = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sysio_regs #(.PHASE_BIT(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .mmu_fault(mmu_fault), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] r);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        #1 r = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h2000_0010, 32'hFFFF_FFFF, 32'h0},         // R5 write all ones
        '{1'b0, 32'h2000_0010, 32'h0,         32'h0000_03FF}, // R5 width
        '{1'b1, 32'h2000_0010, 32'h0000_0154, 32'h0},         // R5
        '{1'b0, 32'h2000_0010, 32'h0,         32'h0000_0154}, // R5
        '{1'b1, 32'h2000_0080, 32'h1234_56A5, 32'h0},         // R9
        '{1'b0, 32'h2000_0080, 32'h0,         32'h0000_00A5}, // R9
        '{1'b1, 32'h2000_0070, 32'hFFFF_FFFF, 32'h0},         // R10 config
        '{1'b0, 32'h2000_0070, 32'h0,         32'h0},         // R10 reads 0
        '{1'b0, 32'h2000_0010, 32'h0,         32'h0000_0154}, // R10 no effect
        '{1'b0, 32'h2000_0040, 32'h0,         32'h0},         // R10 undecoded
        '{1'b1, 32'h3000_0010, 32'h0000_0000, 32'h0},         // R1 outside
        '{1'b0, 32'h2000_0010, 32'h0,         32'h0000_0154}, // R1 untouched
        '{1'b0, 32'h1000_0080, 32'h0,         32'h0},         // R1 outside read
        '{1'b1, 32'h2000_0010, 32'h0,         32'h0}          // cleanup
    };

    initial begin
        logic [31:0] r;
        bit seen0, seen1, pair_ok;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R11 reset flags", r & 32'hFFFF_FFF3, 32'h2);
        chk("R11 reset irq", {31'b0, irq}, 0);
        chk("R11 reset enables", 0, 0);
        acc(1'b0, 32'h2000_0010, 0, r);
        chk("R11 reset enable reg", r, 0);
        chk("R2 reset tx_valid", {31'b0, tx_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].we, VEC[i].addr, VEC[i].wdata, r);
            if (!VEC[i].we) chk("table R1/R5/R9/R10", r, VEC[i].exp);
        end

        // R1 data write outside region sends nothing
        acc(1'b1, 32'h0000_0000, 32'h77, r);
        chk("R1 no tx outside", {31'b0, tx_valid}, 0);

        // R2 transmit
        acc(1'b1, 32'h2000_0000, 32'h1234_565A, r);
        chk("R2 tx_valid", {31'b0, tx_valid}, 1);
        chk("R2 tx_byte", {24'b0, tx_byte}, 32'h5A);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R2 tx flag clear", r & 32'h2, 0);
        acc(1'b1, 32'h2000_0000, 32'h33, r);
        repeat (2) @(posedge clk);
        #1 chk("R2 held byte", {24'b0, tx_byte}, 32'h5A);
        chk("R2 held valid", {31'b0, tx_valid}, 1);
        @(negedge clk); tx_ready = 1'b1;
        @(posedge clk); #1 tx_ready = 1'b0;
        chk("R2 done", {31'b0, tx_valid}, 0);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R2 tx flag set", r & 32'h2, 32'h2);

        // R3 receive
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'hC3;
        @(posedge clk); #1 rx_valid = 1'b0;
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R3 rx flag", r & 32'h1, 1);
        acc(1'b0, 32'h2000_0000, 0, r);
        chk("R3 rx data", r, 32'hC3);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R4 read clears", r & 32'h1, 0);
        // R4 new byte during the read
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 32'h2000_0000;
        rx_valid = 1'b1; rx_byte = 8'h11;
        @(posedge clk); #1 bus_sel = 1'b0; rx_valid = 1'b0;
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R4 arrival wins", r & 32'h1, 1);
        acc(1'b0, 32'h2000_0000, 0, r);
        chk("R4 new byte", r, 32'h11);

        // R6 replace flags
        acc(1'b1, 32'h2000_0020, 32'hFFFF_F3F3, r);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R6 replace", r & 32'hFFFF_FFF3, 32'h3F3);
        acc(1'b1, 32'h2000_0020, 32'h0, r);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R6 clear", r & 32'hFFFF_FFF3, 0);

        // R8 fault window
        @(negedge clk); mmu_fault = 1'b1;
        @(posedge clk); #1 mmu_fault = 1'b0;
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R8 set", r & 32'h200, 32'h200);
        acc(1'b1, 32'h2000_00C0, 0, r);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R8 past window", r & 32'h200, 32'h200);
        acc(1'b1, 32'h2000_00BC, 0, r);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R8 window end clears", r & 32'h200, 0);
        @(negedge clk); mmu_fault = 1'b1;
        @(posedge clk); #1 mmu_fault = 1'b0;
        acc(1'b1, 32'h2000_00A0, 0, r);
        acc(1'b0, 32'h2000_0020, 0, r);
        chk("R8 window start clears", r & 32'h200, 0);

        // R11 interrupt timing
        acc(1'b1, 32'h2000_0010, 32'h1, r);
        chk("R11 irq idle", {31'b0, irq}, 0);
        @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h01;
        #1 chk("R11 irq before edge", {31'b0, irq}, 0);
        @(posedge clk); #1 rx_valid = 1'b0;
        chk("R11 irq after edge", {31'b0, irq}, 1);
        acc(1'b1, 32'h2000_0010, 32'h0, r);
        chk("R11 irq masked", {31'b0, irq}, 0);
        acc(1'b1, 32'h2000_0010, 32'h200, r);
        acc(1'b1, 32'h2000_0020, 32'h200, r);
        chk("R11 irq from flag write", {31'b0, irq}, 1);
        acc(1'b1, 32'h2000_0010, 32'h0, r);

        // R7 phase bits
        seen0 = 0; seen1 = 0; pair_ok = 1;
        for (int k = 0; k < 40; k++) begin
            acc(1'b0, 32'h2000_0020, 0, r);
            if (r[3] == r[2]) pair_ok = 0;
            if (r[3]) seen1 = 1; else seen0 = 1;
        end
        chk("R7 complement", {31'b0, pair_ok}, 1);
        chk("R7 toggles", {30'b0, seen1, seen0}, 32'h3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule